// File: doc/BRIEF.md
# Clear Channel Assessment Combiner

This block decides, cycle by cycle, whether a direct-sequence spread-spectrum receiver should report its channel as busy. It watches three flags from neighbouring receive logic: an energy-detect result, the lock status of the gain-control loop, and a per-dwell correlation-quality result. From the lock status it derives a sticky carrier-sense flag. It then folds energy and carrier information into one channel indication. A mode field, an output polarity bit and an optional glitch-free sampled mode shape that indication.

A dwell timer with a clock enable divides time into dwells of `DWELL_CYC` cycles. It fires a single-cycle correlation strobe at offset `SQ_AT` inside each dwell. A correlation result counts as an evaluation only if the gain loop stayed locked for every cycle of the dwell up to and including the strobe. Evaluations drive the step from acquisition into tracking. Tracking holds the channel busy until an end-of-packet pulse arrives or receive is disabled. All ports are plain control and status levels. The block has no streaming data path and no valid/ready handshake, so it never applies back-pressure.

Top module: `cca_assess`

## Requirements
- R1: `cfg_mode` selects the busy term. 2'b00 gives energy only. 2'b01 gives carrier only. 2'b10 gives energy AND carrier. 2'b11 gives energy OR carrier. Here carrier = carrier-sense OR latched correlation flag OR tracking.
- R2: With `cfg_active_low` = 1, `cca_out` is the inverse of the busy term (0 means busy). With 0, `cca_out` = 1 means busy.
- R3: `cs_flag` is 1 in the cycle after any cycle in which `rx_en` = 1 and `agc_locked` = 0.
- R4: The dwell counter runs 0 to DWELL_CYC-1 while `rx_en` = 1. An evaluation happens only at counter value SQ_AT, and only when `agc_locked` was 1 in every cycle of that dwell from count 0 through SQ_AT. The latched correlation flag takes `sq1_good` on an evaluation and holds otherwise.
- R5: An evaluation with `sq1_good` = 0 clears `cs_flag` from the next cycle.
- R6: An evaluation with `sq1_good` = 1 while `cs_flag` = 1 sets `track_flag` from the next cycle.
- R7: With `cs_flag` = 0, TRACK_NEED passing evaluations at consecutive strobes are needed to enter tracking. Any strobe that is not a passing evaluation restarts the count.
- R8: `eop` = 1 clears `track_flag` and the pass count in the next cycle. It takes priority over entry into tracking in the same cycle.
- R9: While `rx_en` = 0, carrier-sense, the correlation flag, the pass count, tracking and the sampled value are cleared, and `cca_out` shows the clear level. The first cycle with `rx_en` = 1 is dwell count 0.
- R10: With `cfg_sampled` = 1, `cca_out` follows a register that loads the busy term only in the last cycle of a dwell. With `cfg_sampled` = 0, `cca_out` follows the busy term in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; low holds acquisition idle |
| eop | input | 1 | End-of-packet pulse, ends tracking |
| ed_flag | input | 1 | Energy-detect result |
| agc_locked | input | 1 | Gain loop lock status (1 = locked) |
| sq1_good | input | 1 | Correlation quality result, read at the strobe |
| cfg_mode | input | 2 | Busy-term combination mode |
| cfg_active_low | input | 1 | Output polarity select |
| cfg_sampled | input | 1 | Select once-per-dwell sampled output |
| cca_out | output | 1 | Channel indication, polarity per cfg_active_low |
| cs_flag | output | 1 | Sticky carrier-sense flag |
| track_flag | output | 1 | Tracking state |

## Verification
Entry into tracking and the end-of-packet exit can land in the same cycle. The bench provokes this by raising `eop` exactly at the strobe of a dwell whose window stayed locked while carrier-sense is set. The expected result is that tracking stays low. A second coincidence comes from the sampled register loading at a dwell end while `rx_en` falls. Random stretches of traffic make both happen again and again. Each cycle is judged against a behavioural model that keeps its own dwell count.

// File: rtl/cca_pkg.sv
package cca_pkg;
  typedef enum logic [1:0] {
    MODE_ENERGY  = 2'b00,
    MODE_CARRIER = 2'b01,
    MODE_BOTH    = 2'b10,
    MODE_EITHER  = 2'b11
  } cca_mode_e;
endpackage

// File: rtl/cca_dwell_timer.sv
module cca_dwell_timer #(
  parameter int DWELL_CYC = 40,
  parameter int SQ_AT     = 34
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  output logic strobe,
  output logic dwell_end
);
  localparam int CW = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1;
  localparam logic [CW-1:0] LAST_C = CW'(DWELL_CYC - 1);
  localparam logic [CW-1:0] SQ_C   = CW'(SQ_AT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!rx_en)         cnt_q <= '0;
    else if (cnt_q == LAST_C) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign strobe    = rx_en && (cnt_q == SQ_C);
  assign dwell_end = rx_en && (cnt_q == LAST_C);

  // R4: the strobe is a single-cycle pulse within a dwell
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
  // R9: counter returns to zero whenever receive is disabled
  a_r9_timer_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (cnt_q == '0));
endmodule

// File: rtl/cca_acq_tracker.sv
module cca_acq_tracker #(
  parameter int TRACK_NEED = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic eop,
  input  logic agc_locked,
  input  logic sq1_good,
  input  logic strobe,
  input  logic dwell_end,
  output logic cs1_q,
  output logic sq1_q,
  output logic track_q
);
  localparam int GW = $clog2(TRACK_NEED + 1);
  localparam logic [GW-1:0] NEED_M1 = GW'(TRACK_NEED - 1);
  localparam logic [GW-1:0] NEED_C  = GW'(TRACK_NEED);

  logic          win_ok_q;
  logic          eval;
  logic          pass;
  logic [GW-1:0] good_q;
  logic          enter;

  assign eval  = strobe && win_ok_q && agc_locked;
  assign pass  = eval && sq1_good;
  assign enter = pass && (cs1_q || (good_q >= NEED_M1));

  // lock window: AND of agc_locked over the dwell cycles seen so far
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          win_ok_q <= 1'b1;
    else if (!rx_en)     win_ok_q <= 1'b1;
    else if (dwell_end)  win_ok_q <= 1'b1;
    else                 win_ok_q <= win_ok_q && agc_locked;
  end

  // sticky carrier sense
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cs1_q <= 1'b0;
    else if (!rx_en)          cs1_q <= 1'b0;
    else if (!agc_locked)     cs1_q <= 1'b1;
    else if (eval && !sq1_good) cs1_q <= 1'b0;
  end

  // latched correlation result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sq1_q <= 1'b0;
    else if (!rx_en) sq1_q <= 1'b0;
    else if (eval)   sq1_q <= sq1_good;
  end

  // consecutive pass counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 good_q <= '0;
    else if (!rx_en || eop)     good_q <= '0;
    else if (strobe) begin
      if (!pass)                good_q <= '0;
      else if (good_q < NEED_C) good_q <= good_q + 1'b1;
    end
  end

  // tracking state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             track_q <= 1'b0;
    else if (!rx_en || eop) track_q <= 1'b0;
    else if (enter)         track_q <= 1'b1;
  end

  a_r3_cs_on_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !agc_locked) |=> cs1_q);
  a_r5_fail_clears_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !sq1_good) |=> !cs1_q);
  a_r6_cs_pass_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && cs1_q && !eop) |=> track_q);
  a_r8_eop_ends_track: assert property (@(posedge clk) disable iff (!rst_n)
    eop |=> !track_q);
  a_r9_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!cs1_q && !sq1_q && !track_q));
  a_r4_no_eval_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !agc_locked && !eop && !track_q) |=> !track_q);
endmodule

// File: rtl/cca_combiner.sv
module cca_combiner
  import cca_pkg::*;
#(
  parameter bit HAS_SAMPLER = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       dwell_end,
  input  logic       ed_flag,
  input  logic       carrier,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_active_low,
  input  logic       cfg_sampled,
  output logic       cca_out
);
  cca_mode_e mode;
  logic      busy_raw;
  logic      busy;
  logic      held;
  logic      chosen;

  assign mode = cca_mode_e'(cfg_mode);

  always_comb begin
    unique case (mode)
      MODE_ENERGY:  busy_raw = ed_flag;
      MODE_CARRIER: busy_raw = carrier;
      MODE_BOTH:    busy_raw = ed_flag && carrier;
      MODE_EITHER:  busy_raw = ed_flag || carrier;
      default:      busy_raw = 1'b0;
    endcase
  end

  assign busy = rx_en && busy_raw;

  generate
    if (HAS_SAMPLER) begin : g_sampler
      logic busy_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         busy_q <= 1'b0;
        else if (!rx_en)    busy_q <= 1'b0;
        else if (dwell_end) busy_q <= busy;
      end
      assign held = rx_en && busy_q;

      // R10: the sampled value only moves at a dwell boundary or on disable
      a_r10_sample_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !dwell_end) |=> $stable(busy_q));
    end else begin : g_no_sampler
      assign held = busy;
    end
  endgenerate

  assign chosen  = cfg_sampled ? held : busy;
  assign cca_out = chosen ^ cfg_active_low;

  // R9: idle level while receive is off
  a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> (cca_out == cfg_active_low));
endmodule

// File: rtl/cca_assess.sv
module cca_assess #(
  parameter int DWELL_CYC  = 40,
  parameter int SQ_AT      = 34,
  parameter int TRACK_NEED = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       eop,
  input  logic       ed_flag,
  input  logic       agc_locked,
  input  logic       sq1_good,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_active_low,
  input  logic       cfg_sampled,
  output logic       cca_out,
  output logic       cs_flag,
  output logic       track_flag
);
  logic strobe, dwell_end;
  logic cs1, sq1, trk;

  cca_dwell_timer #(.DWELL_CYC(DWELL_CYC), .SQ_AT(SQ_AT)) u_timer (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .strobe(strobe), .dwell_end(dwell_end)
  );

  cca_acq_tracker #(.TRACK_NEED(TRACK_NEED)) u_acq (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .eop(eop),
    .agc_locked(agc_locked), .sq1_good(sq1_good),
    .strobe(strobe), .dwell_end(dwell_end),
    .cs1_q(cs1), .sq1_q(sq1), .track_q(trk)
  );

  cca_combiner #(.HAS_SAMPLER(1'b1)) u_comb (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .dwell_end(dwell_end),
    .ed_flag(ed_flag), .carrier(cs1 || sq1 || trk),
    .cfg_mode(cfg_mode), .cfg_active_low(cfg_active_low),
    .cfg_sampled(cfg_sampled), .cca_out(cca_out)
  );

  assign cs_flag    = cs1;
  assign track_flag = trk;

  // R7: tracking cannot begin while the gain loop is unlocked in that cycle
  a_r7_no_entry_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!track_flag && !agc_locked) |=> !track_flag);
endmodule

// File: tb/tb_cca_assess.sv
`timescale 1ns/1ps
module tb_cca_assess;
  localparam int DW = 40, SA = 34, NEED = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, rx_en, eop, ed_flag, agc_locked, sq1_good;
  logic [1:0] cfg_mode;
  logic cfg_active_low, cfg_sampled;
  logic cca_out, cs_flag, track_flag;

  cca_assess #(.DWELL_CYC(DW), .SQ_AT(SA), .TRACK_NEED(NEED)) dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .eop(eop), .ed_flag(ed_flag),
    .agc_locked(agc_locked), .sq1_good(sq1_good), .cfg_mode(cfg_mode),
    .cfg_active_low(cfg_active_low), .cfg_sampled(cfg_sampled),
    .cca_out(cca_out), .cs_flag(cs_flag), .track_flag(track_flag)
  );

  int checks = 0, fails = 0;
  string tag = "R9";
  // behavioural model state
  int m_cnt = 0, m_good = 0;
  bit m_win = 1, m_cs = 0, m_sq = 0, m_trk = 0, m_bq = 0;

  function automatic bit model_busy();
    bit car, r;
    car = m_cs || m_sq || m_trk;
    case (cfg_mode)
      2'b00: r = ed_flag;
      2'b01: r = car;
      2'b10: r = ed_flag && car;
      default: r = ed_flag || car;
    endcase
    return rx_en && r;
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit sel;
    sel = cfg_sampled ? (rx_en && m_bq) : model_busy();
    check(tag, "cca_out", cca_out, sel ^ cfg_active_low);
    check(tag, "cs_flag", cs_flag, m_cs);
    check(tag, "track_flag", track_flag, m_trk);
  endtask

  task automatic model_update();
    bit strobe, last, ev, busy;
    if (!rx_en) begin
      m_cnt = 0; m_win = 1; m_cs = 0; m_sq = 0; m_good = 0; m_trk = 0; m_bq = 0;
    end else begin
      strobe = (m_cnt == SA);
      last   = (m_cnt == DW - 1);
      ev     = strobe && m_win && agc_locked;
      busy   = model_busy();
      if (eop) m_trk = 0;
      else if (!m_trk && ev && sq1_good && (m_cs || m_good + 1 >= NEED)) m_trk = 1;
      if (eop) m_good = 0;
      else if (strobe) m_good = (ev && sq1_good) ? ((m_good < NEED) ? m_good + 1 : m_good) : 0;
      if (!agc_locked) m_cs = 1;
      else if (ev && !sq1_good) m_cs = 0;
      if (ev) m_sq = sq1_good;
      if (last) m_bq = busy;
      m_win = last ? 1'b1 : (m_win && agc_locked);
      m_cnt = last ? 0 : m_cnt + 1;
    end
  endtask

  // one cycle: inputs already driven after a negedge
  task automatic step();
    #1;
    compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; rx_en = 0; eop = 0; ed_flag = 0; agc_locked = 1; sq1_good = 0;
    cfg_mode = 2'b01; cfg_active_low = 0; cfg_sampled = 0;
    repeat (3) @(negedge clk);
    // R9: reset / idle level, both polarities
    #1 check("R9", "reset cca", cca_out, 1'b0);
    check("R9", "reset cs", cs_flag, 1'b0);
    check("R9", "reset track", track_flag, 1'b0);
    cfg_active_low = 1; #1 check("R2", "idle low-active", cca_out, 1'b1);
    @(negedge clk); rst_n = 1; cfg_active_low = 0;
    tag = "R9"; ed_flag = 1; run(4);

    // R3: unlock sets carrier sense
    tag = "R3"; rx_en = 1; ed_flag = 0; agc_locked = 0; run(3);
    check("R3", "cs after unlock", cs_flag, 1'b1);
    // R5: relock for a whole dwell, bad correlation clears it
    tag = "R5"; agc_locked = 1; sq1_good = 0; run(2 * DW + 2);
    check("R5", "cs after failed eval", cs_flag, 1'b0);

    // R6: unlock, then one passing evaluation enters tracking
    tag = "R6"; agc_locked = 0; run(2); agc_locked = 1; sq1_good = 1;
    run(2 * DW);
    check("R6", "tracking via cs", track_flag, 1'b1);
    // R8: end of packet leaves tracking
    tag = "R8"; eop = 1; step(); eop = 0;
    check("R8", "eop exit", track_flag, 1'b0);
    run(5);

    // R8: eop in the very cycle tracking would be entered
    rx_en = 0; step(); rx_en = 1; agc_locked = 0; run(3); agc_locked = 1; sq1_good = 1;
    while (!(m_cnt == SA && m_win)) step();
    eop = 1; step(); eop = 0;
    check("R8", "eop beats entry", track_flag, 1'b0);

    // R7: no cs, two consecutive passes needed; a bad one restarts
    tag = "R7"; rx_en = 0; step(); rx_en = 1; agc_locked = 1; sq1_good = 1;
    run(DW);
    check("R7", "one pass not enough", track_flag, 1'b0);
    sq1_good = 0; run(DW); sq1_good = 1; run(DW);
    check("R7", "restart after fail", track_flag, 1'b0);
    run(DW);
    check("R7", "two passes track", track_flag, 1'b1);

    // R1 / R2: mode and polarity sweep
    for (int p = 0; p < 2; p++) begin
      cfg_active_low = p[0];
      for (int md = 0; md < 4; md++) begin
        cfg_mode = md[1:0];
        tag = "R1"; ed_flag = 0; run(2); ed_flag = 1; run(2);
        tag = "R2"; rx_en = 0; run(2); rx_en = 1; ed_flag = 0; run(2); ed_flag = 1; run(2);
      end
    end
    cfg_active_low = 0;

    // R10: sampled output with toggling energy
    tag = "R10"; cfg_mode = 2'b00; cfg_sampled = 1;
    for (int i = 0; i < 3 * DW; i++) begin ed_flag = i[2]; step(); end
    cfg_sampled = 0; run(4);

    // R4: random traffic
    tag = "R4";
    for (int i = 0; i < 6000; i++) begin
      agc_locked = ($urandom_range(0, 199) != 0);
      sq1_good   = ($urandom_range(0, 3) != 0);
      ed_flag    = $urandom_range(0, 1);
      eop        = ($urandom_range(0, 299) == 0);
      rx_en      = ($urandom_range(0, 499) != 0);
      if ($urandom_range(0, 99) == 0) cfg_mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 199) == 0) cfg_sampled = ~cfg_sampled;
      if ($urandom_range(0, 299) == 0) cfg_active_low = ~cfg_active_low;
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule